// File: doc/BRIEF.md
# Spare Rank Selection and Failover

This block handles rank sparing for a single memory channel. When a configuration is started, it takes the number of populated ranks, a size code for each rank, the DIMM organisation (single, dual or quad rank per DIMM) and a sparing mode. It then works out which ranks are held back as spares. Ranks that are not spares carry data, and each of them is addressed by its own physical index.

After configuration, the block accepts failing-rank events. It moves each failing data rank onto the next unused spare, in the order the spares were chosen, so a single channel can survive several failures in succession. A combinational lookup turns a logical (data) rank into the physical rank that now serves it. The lookup marks as invalid any rank that is a spare or that lies outside the populated count.

Top module: `rank_spare_mgr`

## Requirements
- R1: After reset, cfg_done, cfg_shortfall and spare_err are 0, and lookup_valid is 0 for every rank, because no ranks are configured.
- R2: The requested spare count comes from cfg_mode. Code 0 (auto) requests floor(rank_count/2), and codes 1, 2 and 3 request that number. The request is clamped to 2 (MAX_SPARES), and at most rank_count-1 spares are ever selected.
- R3: A rank becomes a spare only if it is below rank_count and its size code (bits [3r+2:3r] of cfg_sizes) equals the largest size code among the populated ranks.
- R4: Among qualifying ranks, odd-indexed ranks (the non-terminating ranks) are taken first when cfg_dimm_type is 1 (dual) or 2 (quad). After them, the remaining qualifiers are taken by ascending index. With cfg_dimm_type 0 (single) there is no preference, and selection is by ascending index. The first rank chosen becomes spare slot 0 and the next becomes slot 1.
- R5: cfg_shortfall is 1 after configuration exactly when fewer spares were selected than the clamped request.
- R6: A cfg_start pulse latches the configuration, clears all remapping and spare_err, and drops cfg_done. cfg_done rises 3*NUM_RANKS+1 cycles after the start edge and then holds until the next cfg_start.
- R7: A fail_valid event while cfg_done is 0 has no effect on the remap table or on spare_err.
- R8: An accepted failure remaps the failing rank onto the lowest unused spare slot, so the first failure goes to slot 0 and the second to slot 1.
- R9: A failure on a rank that is out of range, is a spare, or is already remapped, or that arrives when no spare is left, changes no mapping and sets spare_err. spare_err stays set until cfg_start.
- R10: For a populated non-spare rank, lookup_valid is 1 and lookup_phys is that rank, or its spare if the rank has failed. For spares and out-of-range ranks, lookup_valid is 0 and lookup_phys is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse that starts configuration |
| cfg_rank_count | input | CNT_W | Number of populated ranks |
| cfg_sizes | input | NUM_RANKS*SIZE_W | Per-rank size codes; rank r at [r*SIZE_W +: SIZE_W] |
| cfg_dimm_type | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| cfg_mode | input | 2 | 0 auto, 1/2/3 explicit spare request |
| fail_valid | input | 1 | Failing-rank event strobe |
| fail_rank | input | RANK_W | Rank reported failing |
| lookup_rank | input | RANK_W | Logical rank to translate |
| cfg_done | output | 1 | Spare selection finished |
| cfg_shortfall | output | 1 | Fewer spares qualified than requested |
| spare_err | output | 1 | Sticky rejected-failover flag |
| lookup_valid | output | 1 | lookup_rank is a populated data rank |
| lookup_phys | output | RANK_W | Physical rank serving lookup_rank |

## Verification
The hardest case to reach is the one where size ties and DIMM position pull in different directions. Here the odd-index preference and the ascending fallback both pick ranks, and the slot order they produce then decides where each later failure lands. The stimulus sets up a dual-rank channel in which only one odd rank shares the largest size with even ranks. It then fails two data ranks in turn and reads both targets back through the lookup, followed by a third failure that finds the spares exhausted. Failure events injected while selection is still running are checked afterwards through the lookup and the error flag.

// File: rtl/rsp_pkg.sv
// Package: shared encodings for the spare rank manager.
// Assumes: mode and DIMM-type ports carry these codes unchanged.
package rsp_pkg;
    typedef enum logic [1:0] {
        MODE_AUTO  = 2'd0,
        MODE_ONE   = 2'd1,
        MODE_TWO   = 2'd2,
        MODE_THREE = 2'd3
    } spare_mode_e;

    typedef enum logic [1:0] {
        DIMM_SINGLE = 2'd0,
        DIMM_DUAL   = 2'd1,
        DIMM_QUAD   = 2'd2,
        DIMM_QUAD_X = 2'd3
    } dimm_e;

    typedef enum logic [2:0] {
        SEL_IDLE = 3'd0,
        SEL_MAX  = 3'd1,
        SEL_PREF = 3'd2,
        SEL_REST = 3'd3,
        SEL_FIN  = 3'd4
    } sel_state_e;
endpackage

// File: rtl/rsp_rank_class.sv
// Module: per-rank classification (populated, non-terminating position).
// Assumes: ranks are numbered so that, on dual and quad DIMMs, odd indices
// are the non-terminating ranks; single-rank DIMMs have no such rank.
module rsp_rank_class #(
    parameter int NUM_RANKS = 8,
    parameter int CNT_W     = 4
) (
    input  logic [CNT_W-1:0]     rank_count,
    input  logic [1:0]           dimm_type,
    output logic [NUM_RANKS-1:0] in_range,
    output logic [NUM_RANKS-1:0] nonterm
);
    import rsp_pkg::*;

    logic multi_rank;
    // Purpose: any DIMM organisation other than single rank has inner ranks.
    assign multi_rank = (dimm_e'(dimm_type) != DIMM_SINGLE);

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
        localparam bit ODD = (g % 2) == 1;
        assign in_range[g] = (CNT_W'(g) < rank_count);
        assign nonterm[g]  = multi_rank && ODD;
    end
endmodule

// File: rtl/rsp_selector.sv
// Module: multi-cycle spare selection sequencer.
// Three scans over the ranks, one rank per cycle: find the largest size,
// take preferred (non-terminating) qualifiers, then take the remaining
// qualifiers. Then one cycle to finish. Assumes cfg_start is a pulse; a new
// pulse restarts the sequence from any state.
module rsp_selector #(
    parameter int NUM_RANKS  = 8,
    parameter int SIZE_W     = 3,
    parameter int MAX_SPARES = 2,
    parameter int RANK_W     = 3,
    parameter int CNT_W      = 4,
    parameter int SLOT_W     = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_start,
    input  logic [CNT_W-1:0]            cfg_rank_count,
    input  logic [NUM_RANKS*SIZE_W-1:0] cfg_sizes,
    input  logic [1:0]                  cfg_dimm_type,
    input  logic [1:0]                  cfg_mode,
    output logic                        done,
    output logic                        shortfall,
    output logic [CNT_W-1:0]            count_q,
    output logic [NUM_RANKS-1:0]        spare_mask,
    output logic [MAX_SPARES*RANK_W-1:0] spare_ids,
    output logic [CNT_W-1:0]            spare_cnt
);
    import rsp_pkg::*;

    sel_state_e                  state_q;
    logic [RANK_W-1:0]           idx_q;
    logic [SIZE_W-1:0]           max_q;
    logic [CNT_W-1:0]            pick_q;
    logic [NUM_RANKS*SIZE_W-1:0] sizes_q;
    logic [1:0]                  type_q;
    logic [1:0]                  mode_q;
    logic [RANK_W-1:0]           id_q [MAX_SPARES];

    logic [NUM_RANKS-1:0] in_range;
    logic [NUM_RANKS-1:0] nonterm;

    rsp_rank_class #(
        .NUM_RANKS (NUM_RANKS),
        .CNT_W     (CNT_W)
    ) u_class (
        .rank_count (count_q),
        .dimm_type  (type_q),
        .in_range   (in_range),
        .nonterm    (nonterm)
    );

    logic [CNT_W-1:0]  req_raw;
    logic [CNT_W-1:0]  req_n;
    logic [CNT_W-1:0]  cap_n;
    logic [CNT_W-1:0]  limit_n;
    logic [SIZE_W-1:0] cur_size;
    logic              qualify;
    logic              room;
    logic              take_pref;
    logic              take_rest;
    logic              last_idx;

    // Purpose: requested spare count from the mode, clamped and capped.
    always_comb begin
        case (spare_mode_e'(mode_q))
            MODE_AUTO:  req_raw = count_q >> 1;
            MODE_ONE:   req_raw = CNT_W'(1);
            MODE_TWO:   req_raw = CNT_W'(2);
            MODE_THREE: req_raw = CNT_W'(3);
            default:    req_raw = '0;
        endcase
        req_n   = (req_raw > CNT_W'(MAX_SPARES)) ? CNT_W'(MAX_SPARES) : req_raw;
        cap_n   = (count_q == '0) ? '0 : count_q - CNT_W'(1);
        limit_n = (req_n > cap_n) ? cap_n : req_n;
    end

    // Purpose: qualification of the rank under the scan pointer.
    always_comb begin
        cur_size  = sizes_q[idx_q*SIZE_W +: SIZE_W];
        qualify   = in_range[idx_q] && (cur_size == max_q);
        room      = (pick_q < limit_n);
        take_pref = (state_q == SEL_PREF) && qualify && nonterm[idx_q] && room;
        take_rest = (state_q == SEL_REST) && qualify && !spare_mask[idx_q] && room;
        last_idx  = (idx_q == RANK_W'(NUM_RANKS - 1));
    end

    // Purpose: selection state machine and spare list registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEL_IDLE;
            idx_q      <= '0;
            max_q      <= '0;
            pick_q     <= '0;
            count_q    <= '0;
            sizes_q    <= '0;
            type_q     <= '0;
            mode_q     <= '0;
            spare_mask <= '0;
            done       <= 1'b0;
            shortfall  <= 1'b0;
            for (int s = 0; s < MAX_SPARES; s++) id_q[s] <= '0;
        end else if (cfg_start) begin
            state_q    <= SEL_MAX;
            idx_q      <= '0;
            max_q      <= '0;
            pick_q     <= '0;
            count_q    <= cfg_rank_count;
            sizes_q    <= cfg_sizes;
            type_q     <= cfg_dimm_type;
            mode_q     <= cfg_mode;
            spare_mask <= '0;
            done       <= 1'b0;
            shortfall  <= 1'b0;
            for (int s = 0; s < MAX_SPARES; s++) id_q[s] <= '0;
        end else begin
            case (state_q)
                SEL_MAX: begin
                    if (in_range[idx_q] && (cur_size > max_q)) max_q <= cur_size;
                    idx_q <= last_idx ? '0 : idx_q + RANK_W'(1);
                    if (last_idx) state_q <= SEL_PREF;
                end
                SEL_PREF, SEL_REST: begin
                    if (take_pref || take_rest) begin
                        spare_mask[idx_q]            <= 1'b1;
                        id_q[pick_q[SLOT_W-1:0]]     <= idx_q;
                        pick_q                       <= pick_q + CNT_W'(1);
                    end
                    idx_q <= last_idx ? '0 : idx_q + RANK_W'(1);
                    if (last_idx) state_q <= (state_q == SEL_PREF) ? SEL_REST : SEL_FIN;
                end
                SEL_FIN: begin
                    shortfall <= (pick_q < req_n);
                    done      <= 1'b1;
                    state_q   <= SEL_IDLE;
                end
                default: state_q <= SEL_IDLE;
            endcase
        end
    end

    for (genvar s = 0; s < MAX_SPARES; s++) begin : g_ids
        assign spare_ids[s*RANK_W +: RANK_W] = id_q[s];
    end
    assign spare_cnt = pick_q;

    AST_SPARE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spare_mask) <= MAX_SPARES); // R2
    AST_SPARE_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((spare_mask & ~in_range) == '0)); // R3
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_start) |=> done); // R6
    AST_SHORT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        shortfall |-> done); // R5
endmodule

// File: rtl/rsp_failover.sv
// Module: failover sequencing, remap table and combinational lookup.
// Assumes spare_ids is filled in selection order and stable while enable
// (configuration done) is high; clr clears all remap state.
module rsp_failover #(
    parameter int NUM_RANKS  = 8,
    parameter int MAX_SPARES = 2,
    parameter int RANK_W     = 3,
    parameter int CNT_W      = 4,
    parameter int SLOT_W     = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         enable,
    input  logic                         fail_valid,
    input  logic [RANK_W-1:0]            fail_rank,
    input  logic [CNT_W-1:0]             rank_count,
    input  logic [NUM_RANKS-1:0]         spare_mask,
    input  logic [MAX_SPARES*RANK_W-1:0] spare_ids,
    input  logic [CNT_W-1:0]             spare_cnt,
    input  logic [RANK_W-1:0]            lookup_rank,
    output logic                         lookup_valid,
    output logic [RANK_W-1:0]            lookup_phys,
    output logic                         spare_err
);
    logic [NUM_RANKS-1:0] failed_q;
    logic [SLOT_W-1:0]    slot_q [NUM_RANKS];
    logic [CNT_W-1:0]     used_q;
    logic [RANK_W-1:0]    ids [MAX_SPARES];

    for (genvar s = 0; s < MAX_SPARES; s++) begin : g_unpack
        assign ids[s] = spare_ids[s*RANK_W +: RANK_W];
    end

    logic fail_in_range;
    logic fail_ok;
    // Purpose: decide whether a failure event can consume a spare.
    always_comb begin
        fail_in_range = (CNT_W'(fail_rank) < rank_count);
        fail_ok = fail_in_range && !spare_mask[fail_rank] &&
                  !failed_q[fail_rank] && (used_q < spare_cnt);
    end

    // Purpose: remap table update and sticky error on rejected events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            failed_q  <= '0;
            used_q    <= '0;
            spare_err <= 1'b0;
            for (int r = 0; r < NUM_RANKS; r++) slot_q[r] <= '0;
        end else if (enable && fail_valid) begin
            if (fail_ok) begin
                failed_q[fail_rank] <= 1'b1;
                slot_q[fail_rank]   <= used_q[SLOT_W-1:0];
                used_q              <= used_q + CNT_W'(1);
            end else begin
                spare_err <= 1'b1;
            end
        end
    end

    // Purpose: translate a logical rank to the physical rank serving it.
    always_comb begin
        lookup_valid = (CNT_W'(lookup_rank) < rank_count) && !spare_mask[lookup_rank];
        if (!lookup_valid)
            lookup_phys = '0;
        else if (failed_q[lookup_rank])
            lookup_phys = ids[slot_q[lookup_rank]];
        else
            lookup_phys = lookup_rank;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_err && !clr) |=> spare_err); // R9
    AST_NO_EARLY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr) |=> $stable(failed_q)); // R7
    AST_REMAP_TO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && (lookup_phys != lookup_rank)) |-> spare_mask[lookup_phys]); // R10
    AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= spare_cnt); // R8
endmodule

// File: rtl/rank_spare_mgr.sv
// Module: top of the per-channel rank sparing manager.
// Selects spare ranks after cfg_start, then remaps failing ranks onto them
// and offers a combinational logical-to-physical rank lookup.
// Assumes one channel, synchronous active-low reset, cfg_start as a pulse.
module rank_spare_mgr #(
    parameter int NUM_RANKS  = 8,
    parameter int SIZE_W     = 3,
    parameter int MAX_SPARES = 2,
    localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int CNT_W     = $clog2(NUM_RANKS + 1),
    localparam int SLOT_W    = (MAX_SPARES > 1) ? $clog2(MAX_SPARES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_start,
    input  logic [CNT_W-1:0]            cfg_rank_count,
    input  logic [NUM_RANKS*SIZE_W-1:0] cfg_sizes,
    input  logic [1:0]                  cfg_dimm_type,
    input  logic [1:0]                  cfg_mode,
    input  logic                        fail_valid,
    input  logic [RANK_W-1:0]           fail_rank,
    input  logic [RANK_W-1:0]           lookup_rank,
    output logic                        cfg_done,
    output logic                        cfg_shortfall,
    output logic                        spare_err,
    output logic                        lookup_valid,
    output logic [RANK_W-1:0]           lookup_phys
);
    logic [CNT_W-1:0]             count_q;
    logic [NUM_RANKS-1:0]         spare_mask;
    logic [MAX_SPARES*RANK_W-1:0] spare_ids;
    logic [CNT_W-1:0]             spare_cnt;

    rsp_selector #(
        .NUM_RANKS  (NUM_RANKS),
        .SIZE_W     (SIZE_W),
        .MAX_SPARES (MAX_SPARES),
        .RANK_W     (RANK_W),
        .CNT_W      (CNT_W),
        .SLOT_W     (SLOT_W)
    ) u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_start      (cfg_start),
        .cfg_rank_count (cfg_rank_count),
        .cfg_sizes      (cfg_sizes),
        .cfg_dimm_type  (cfg_dimm_type),
        .cfg_mode       (cfg_mode),
        .done           (cfg_done),
        .shortfall      (cfg_shortfall),
        .count_q        (count_q),
        .spare_mask     (spare_mask),
        .spare_ids      (spare_ids),
        .spare_cnt      (spare_cnt)
    );

    rsp_failover #(
        .NUM_RANKS  (NUM_RANKS),
        .MAX_SPARES (MAX_SPARES),
        .RANK_W     (RANK_W),
        .CNT_W      (CNT_W),
        .SLOT_W     (SLOT_W)
    ) u_fo (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (cfg_start),
        .enable       (cfg_done),
        .fail_valid   (fail_valid),
        .fail_rank    (fail_rank),
        .rank_count   (count_q),
        .spare_mask   (spare_mask),
        .spare_ids    (spare_ids),
        .spare_cnt    (spare_cnt),
        .lookup_rank  (lookup_rank),
        .lookup_valid (lookup_valid),
        .lookup_phys  (lookup_phys),
        .spare_err    (spare_err)
    );

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (!cfg_done && !spare_err)); // R6
endmodule

// File: tb/rank_spare_mgr_tb.sv
module rank_spare_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_start = 1'b0;
    logic [3:0]    cfg_rank_count = '0;
    logic [N*SW-1:0] cfg_sizes = '0;
    logic [1:0]    cfg_dimm_type = '0;
    logic [1:0]    cfg_mode = '0;
    logic          fail_valid = 1'b0;
    logic [2:0]    fail_rank = '0;
    logic [2:0]    lookup_rank = '0;
    logic          cfg_done, cfg_shortfall, spare_err, lookup_valid;
    logic [2:0]    lookup_phys;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    rank_spare_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .cfg_rank_count(cfg_rank_count), .cfg_sizes(cfg_sizes),
        .cfg_dimm_type(cfg_dimm_type), .cfg_mode(cfg_mode),
        .fail_valid(fail_valid), .fail_rank(fail_rank),
        .lookup_rank(lookup_rank), .cfg_done(cfg_done),
        .cfg_shortfall(cfg_shortfall), .spare_err(spare_err),
        .lookup_valid(lookup_valid), .lookup_phys(lookup_phys)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic [N*SW-1:0] fill(input logic [SW-1:0] v);
        logic [N*SW-1:0] x;
        for (int r = 0; r < N; r++) x[r*SW +: SW] = v;
        return x;
    endfunction

    task automatic lk(input string req, input int r, input int ev, input int ep);
        lookup_rank = 3'(r);
        #1;
        check({req, " valid"}, int'(lookup_valid), ev);
        check({req, " phys"}, int'(lookup_phys), ep);
    endtask

    task automatic start_cfg(input int cnt, input int typ, input int mode,
                             input logic [N*SW-1:0] sz, output int cycles);
        @(negedge clk);
        cfg_rank_count = 4'(cnt);
        cfg_dimm_type  = 2'(typ);
        cfg_mode       = 2'(mode);
        cfg_sizes      = sz;
        cfg_start      = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        cycles = 0;
        while (!cfg_done && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic do_fail(input int r);
        @(negedge clk);
        fail_valid = 1'b1;
        fail_rank  = 3'(r);
        @(negedge clk);
        fail_valid = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        check("R1 done", int'(cfg_done), 0);
        check("R1 shortfall", int'(cfg_shortfall), 0);
        check("R1 err", int'(spare_err), 0);
        for (int r = 0; r < N; r++) lk("R1 lookup", r, 0, 0);
    endtask

    // R2/R4/R6/R8/R9/R10: auto mode, dual, equal sizes -> spares 1,3
    task automatic t_auto_dual();
        int cyc;
        start_cfg(8, 1, 0, fill(3'd2), cyc);
        check("R6 done latency", cyc, 3*N+1);
        check("R5 shortfall", int'(cfg_shortfall), 0);
        lk("R4 spare1", 1, 0, 0);
        lk("R4 spare3", 3, 0, 0);
        lk("R10 rank0", 0, 1, 0);
        lk("R10 rank2", 2, 1, 2);
        lk("R2 rank5 not spare", 5, 1, 5);
        do_fail(2);
        lk("R8 first fail", 2, 1, 1);
        check("R9 no err", int'(spare_err), 0);
        do_fail(5);
        lk("R8 second fail", 5, 1, 3);
        do_fail(6);
        check("R9 exhausted err", int'(spare_err), 1);
        lk("R9 rank6 unchanged", 6, 1, 6);
        do_fail(0);
        @(negedge clk);
        check("R9 err sticky", int'(spare_err), 1);
        lk("R9 rank0 unchanged", 0, 1, 0);
    endtask

    // R3/R5: only one rank holds the largest size
    task automatic t_size_rule();
        int cyc;
        logic [N*SW-1:0] sz;
        sz = fill(3'd2);
        sz[4*SW +: SW] = 3'd5;
        start_cfg(8, 2, 2, sz, cyc);
        check("R6 err cleared", int'(spare_err), 0);
        check("R5 shortfall set", int'(cfg_shortfall), 1);
        lk("R3 rank4 spare", 4, 0, 0);
        lk("R3 rank1 data", 1, 1, 1);
        lk("R3 rank3 data", 3, 1, 3);
    endtask

    // R4: single-rank DIMMs, mode 1 -> rank 0
    task automatic t_single();
        int cyc;
        start_cfg(4, 0, 1, fill(3'd1), cyc);
        lk("R4 single spare0", 0, 0, 0);
        lk("R4 single rank1", 1, 1, 1);
        lk("R10 out of range", 5, 0, 0);
        check("R5 no shortfall", int'(cfg_shortfall), 0);
    endtask

    // R2: mode 3 clamps to 2, no shortfall
    task automatic t_clamp();
        int cyc;
        start_cfg(8, 2, 3, fill(3'd4), cyc);
        check("R2 clamp shortfall", int'(cfg_shortfall), 0);
        lk("R2 quad spare1", 1, 0, 0);
        lk("R2 quad spare3", 3, 0, 0);
        lk("R2 rank5 data", 5, 1, 5);
    endtask

    // R7: failure events during selection are ignored
    task automatic t_early_fail();
        int cyc;
        @(negedge clk);
        cfg_rank_count = 4'd8; cfg_dimm_type = 2'd1; cfg_mode = 2'd0;
        cfg_sizes = fill(3'd2); cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0; fail_valid = 1'b1; fail_rank = 3'd0;
        @(negedge clk);
        fail_rank = 3'd1;
        @(negedge clk);
        fail_valid = 1'b0;
        cyc = 0;
        while (!cfg_done && cyc < 200) begin @(negedge clk); cyc++; end
        check("R7 err", int'(spare_err), 0);
        lk("R7 rank0 unmapped", 0, 1, 0);
        do_fail(0);
        lk("R7 rank0 after done", 0, 1, 1);
    endtask

    // R2: auto with 3 ranks -> 1 spare; mode 2 with 2 ranks capped to 1
    task automatic t_small();
        int cyc;
        start_cfg(3, 1, 0, fill(3'd3), cyc);
        lk("R2 auto3 spare1", 1, 0, 0);
        lk("R2 auto3 rank2", 2, 1, 2);
        check("R2 auto3 shortfall", int'(cfg_shortfall), 0);
        start_cfg(2, 1, 2, fill(3'd3), cyc);
        lk("R2 cap spare1", 1, 0, 0);
        lk("R2 cap rank0", 0, 1, 0);
        check("R5 cap shortfall", int'(cfg_shortfall), 1);
        do_fail(1);
        check("R9 fail on spare", int'(spare_err), 1);
    endtask

    // R4/R8: mixed tie, odd preference then ascending fallback
    task automatic t_mixed();
        int cyc;
        logic [N*SW-1:0] sz;
        sz = '0;
        sz[0*SW +: SW] = 3'd3; sz[1*SW +: SW] = 3'd1;
        sz[2*SW +: SW] = 3'd3; sz[3*SW +: SW] = 3'd1;
        sz[4*SW +: SW] = 3'd3; sz[5*SW +: SW] = 3'd3;
        sz[6*SW +: SW] = 3'd7; sz[7*SW +: SW] = 3'd7;
        start_cfg(6, 1, 2, sz, cyc);
        lk("R4 mixed spare5", 5, 0, 0);
        lk("R4 mixed spare0", 0, 0, 0);
        lk("R4 mixed rank1 data", 1, 1, 1);
        do_fail(2);
        lk("R8 slot0 target", 2, 1, 5);
        do_fail(4);
        lk("R8 slot1 target", 4, 1, 0);
        do_fail(3);
        check("R9 mixed exhausted", int'(spare_err), 1);
        do_fail(7);
        lk("R9 out of range rank7", 7, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_dual();
        t_size_rule();
        t_single();
        t_clamp();
        t_early_fail();
        t_small();
        t_mixed();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule